// File: doc/BRIEF.md
# Clock Generator Configuration Register Bank with Strap Latch

This block holds the software-visible configuration of a multi-output clock generator. It is a bank of eight byte-wide registers reached through a 3-bit byte address. It has one write strobe and one read strobe. Read data is registered and appears on the cycle after the read strobe. The register contents drive the generator's controls directly: output enables, per-output edge-rate selects, differential amplitude, reference-clock edge rate, reference enable and the reference keep-alive (wake-on-LAN) bit.

Two board straps are sampled once, on the first startup event after reset. The first is a three-level spread-spectrum select, which arrives already decoded into a 2-bit level. The second is a one-bit address-select strap. The latched spread level sets the default spread-spectrum amount and can be read back through a read-only field. Software can replace the strap's choice, but only after it sets a dedicated override-enable bit. The latched address-select value is exported for the serial interface logic that sits outside this block.

Top module: `clkcfg_regs`

## Requirements
- R1: After reset the outputs and read data are as follows.
  - Register 0 reads 0xFF.
  - Register 2 reads 0xFF.
  - Register 1 reads 0x06: override off, override code 00, bit 2 = 1, amplitude 10.
  - Register 3 reads 0x5F: reference slew 01, keep-alive 0, reference enable 1, low nibble 1111.
  - Register 7 reads 0x08.
  - out_en_o = 0xFF, out_slew_o = 0xFF, amp_code_o = 10, spread_mode_o = 00, addr_sel_o = 0.
- R2: The straps are captured on the first clock edge at which startup_i is 1 after reset. Later startup pulses and strap changes have no effect until the next reset. Before the capture, the latched level is low and addr_sel_o is 0.
- R3: Register 1 bits 7:6 are read-only and return the latched spread level.
  - The level input encoding is 00 low, 01 mid, 10 high; 11 is treated as high.
  - The readback is 00 for low, 01 for mid and 11 for high.
- R4: While register 1 bit 5 is 0, spread_mode_o follows the latched level. The mode encoding is 00 off, 01 -0.25 %, 10 -0.5 %. Low gives off, mid gives -0.25 % and high gives -0.5 %.
- R5: While register 1 bit 5 is 1, register 1 bits 4:3 pick the mode instead of the strap. Code 00 gives off, 01 gives -0.25 %, 11 gives -0.5 %, and the reserved code 10 gives off.
- R6: A write takes effect on the outputs one cycle later, as follows.
  - Register 0 sets out_en_o and register 2 sets out_slew_o (bit n belongs to output n).
  - Register 1 bits 1:0 set amp_code_o.
  - Register 3 bits 7:6 set ref_slew_o, bit 5 sets ref_wol_o and bit 4 sets ref_en_o.
- R7: Register 7 bits 4:0 hold a writable read byte count. Bits 7:5 always read 0.
- R8: Writes to the read-only and reserved bits are ignored:
  - register 4 always reads 0x00;
  - register 5 always reads 0x11;
  - register 6 always reads 0x08;
  - register 1 bits 7:6 keep the strap readback and bit 2 reads 1;
  - register 3 bits 3:0 read 1111.
- R9: rdata_o is loaded on the clock edge at which rd_en_i is 1, with the register addressed by addr_i. It holds its value on all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| startup_i | input | 1 | Startup event; the first high cycle captures the straps |
| ss_level_i | input | 2 | Decoded spread strap level (00 low, 01 mid, 10 high) |
| addr_strap_i | input | 1 | Address-select strap |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| spread_mode_o | output | 2 | Effective spread mode (00 off, 01 -0.25 %, 10 -0.5 %) |
| amp_code_o | output | 2 | Differential amplitude code |
| out_en_o | output | 8 | Per-output enable |
| out_slew_o | output | 8 | Per-output fast edge-rate select |
| ref_slew_o | output | 2 | Reference edge-rate code |
| ref_wol_o | output | 1 | Reference keeps running in power-down |
| ref_en_o | output | 1 | Reference output enable |
| addr_sel_o | output | 1 | Latched address-select strap |

## Verification
The assertions assume the following:
- rd_en_i and wr_en_i are held at 0 while reset is active, so the first cycle after reset starts from a quiet bus.
- Strap inputs are stable and valid on the cycle startup_i is first raised.

The bench keeps to these assumptions. It drives every input at the falling clock edge and holds both strobes low through each reset. It sets the straps before reset is released and pulses startup_i only afterwards. It never reads and writes the same register in one cycle, because that case would return the older value and the checks do not cover it.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
// Shared constants, encodings and decode helpers for the configuration bank.
// Assumes a byte-wide bank whose output count equals the byte width.
package clkcfg_pkg;
    localparam int DATA_W  = 8;
    localparam int NUM_OUT = DATA_W;
    localparam int ADDR_W  = 3;
    localparam int NUM_REG = 1 << ADDR_W;

    // Register indices
    localparam logic [ADDR_W-1:0] REG_OE    = 3'd0;
    localparam logic [ADDR_W-1:0] REG_SPR   = 3'd1;
    localparam logic [ADDR_W-1:0] REG_SLEW  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_REF   = 3'd3;
    localparam logic [ADDR_W-1:0] REG_RSV   = 3'd4;
    localparam logic [ADDR_W-1:0] REG_REVID = 3'd5;
    localparam logic [ADDR_W-1:0] REG_DEVID = 3'd6;
    localparam logic [ADDR_W-1:0] REG_BCNT  = 3'd7;

    // Effective spread mode encoding
    localparam logic [1:0] SPR_OFF  = 2'b00;
    localparam logic [1:0] SPR_QTR  = 2'b01;
    localparam logic [1:0] SPR_HALF = 2'b10;

    // Decoded strap level encoding
    localparam logic [1:0] LVL_LOW = 2'b00;
    localparam logic [1:0] LVL_MID = 2'b01;

    // Strap level to fixed readback code
    function automatic logic [1:0] level_readback(input logic [1:0] lvl);
        case (lvl)
            LVL_LOW: return 2'b00;
            LVL_MID: return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    // Strap level to spread mode
    function automatic logic [1:0] level_mode(input logic [1:0] lvl);
        case (lvl)
            LVL_LOW: return SPR_OFF;
            LVL_MID: return SPR_QTR;
            default: return SPR_HALF;
        endcase
    endfunction

    // Software code to spread mode; reserved code 10 maps to off
    function automatic logic [1:0] sw_code_mode(input logic [1:0] code);
        case (code)
            2'b01:   return SPR_QTR;
            2'b11:   return SPR_HALF;
            default: return SPR_OFF;
        endcase
    endfunction
endpackage

// File: rtl/clkcfg_strap_latch.sv
`timescale 1ns/1ps
// One-shot capture of the spread level strap and the address-select strap.
// Assumes the straps are valid on the first cycle startup_i is high after reset.
module clkcfg_strap_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       startup_i,
    input  logic [1:0] ss_level_i,
    input  logic       addr_strap_i,
    output logic [1:0] ss_level_o,
    output logic       addr_sel_o,
    output logic       captured_o
);
    import clkcfg_pkg::*;

    logic [1:0] lvl_q;
    logic       adr_q;
    logic       cap_q;

    // Latch straps once on the first startup event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_LOW;
            adr_q <= 1'b0;
            cap_q <= 1'b0;
        end else if (startup_i && !cap_q) begin
            lvl_q <= ss_level_i;
            adr_q <= addr_strap_i;
            cap_q <= 1'b1;
        end
    end

    assign ss_level_o = lvl_q;
    assign addr_sel_o = adr_q;
    assign captured_o = cap_q;

    // R2: once captured, straps are frozen
    a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q |=> (cap_q && $stable(lvl_q) && $stable(adr_q)))
        else $error("strap changed after capture");

    // R2: no capture without a startup event
    a_r2_no_early_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_q && !startup_i) |=> !cap_q)
        else $error("strap captured without startup");
endmodule

// File: rtl/clkcfg_spread_sel.sv
`timescale 1ns/1ps
// Chooses the effective spread mode and forms the strap readback code.
// Purely combinational; the override enable comes from the register file.
module clkcfg_spread_sel (
    input  logic [1:0] strap_level_i,
    input  logic       sw_en_i,
    input  logic [1:0] sw_code_i,
    output logic [1:0] mode_o,
    output logic [1:0] readback_o
);
    import clkcfg_pkg::*;

    // Software code wins only while the override is enabled
    always_comb begin
        readback_o = level_readback(strap_level_i);
        if (sw_en_i) mode_o = sw_code_mode(sw_code_i);
        else         mode_o = level_mode(strap_level_i);
    end
endmodule

// File: rtl/clkcfg_reg_file.sv
`timescale 1ns/1ps
// Eight byte registers with write decode, constant ID bytes and registered read.
// Assumes rd_en_i and wr_en_i are low while reset is active.
module clkcfg_reg_file #(
    parameter int                      BC_W       = 5,
    parameter logic [BC_W-1:0]         BC_RESET   = 5'd8,
    parameter logic [clkcfg_pkg::DATA_W-1:0] REV_VENDOR = 8'h11,
    parameter logic [clkcfg_pkg::DATA_W-1:0] DEVICE_ID  = 8'h08
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic                           rd_en_i,
    input  logic [clkcfg_pkg::ADDR_W-1:0]  addr_i,
    input  logic [clkcfg_pkg::DATA_W-1:0]  wdata_i,
    input  logic [1:0]                     strap_rb_i,
    output logic [clkcfg_pkg::DATA_W-1:0]  rdata_o,
    output logic [clkcfg_pkg::NUM_OUT-1:0] oe_o,
    output logic [clkcfg_pkg::NUM_OUT-1:0] slew_o,
    output logic                           sw_en_o,
    output logic [1:0]                     sw_code_o,
    output logic [1:0]                     amp_o,
    output logic [1:0]                     ref_slew_o,
    output logic                           ref_wol_o,
    output logic                           ref_en_o
);
    import clkcfg_pkg::*;

    localparam int BC_PAD = DATA_W - BC_W;

    logic [NUM_REG-1:0]  wr_hit;
    logic [NUM_OUT-1:0]  oe_q, slew_q;
    logic                sw_en_q;
    logic [1:0]          sw_code_q, amp_q, ref_slew_q;
    logic                ref_wol_q, ref_en_q;
    logic [BC_W-1:0]     bc_q;
    logic [DATA_W-1:0]   rd_mux, rdata_q;

    // One-hot write decode
    always_comb begin
        wr_hit = '0;
        if (wr_en_i) wr_hit[addr_i] = 1'b1;
    end

    // Per-output enable and slew bits, one flop pair per output
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oe_q[g]   <= 1'b1;
                slew_q[g] <= 1'b1;
            end else begin
                if (wr_hit[REG_OE])   oe_q[g]   <= wdata_i[g];
                if (wr_hit[REG_SLEW]) slew_q[g] <= wdata_i[g];
            end
        end
    end

    // Spread override and amplitude fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_en_q   <= 1'b0;
            sw_code_q <= 2'b00;
            amp_q     <= 2'b10;
        end else if (wr_hit[REG_SPR]) begin
            sw_en_q   <= wdata_i[5];
            sw_code_q <= wdata_i[4:3];
            amp_q     <= wdata_i[1:0];
        end
    end

    // Reference control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_slew_q <= 2'b01;
            ref_wol_q  <= 1'b0;
            ref_en_q   <= 1'b1;
        end else if (wr_hit[REG_REF]) begin
            ref_slew_q <= wdata_i[7:6];
            ref_wol_q  <= wdata_i[5];
            ref_en_q   <= wdata_i[4];
        end
    end

    // Read byte count field
    always_ff @(posedge clk) begin
        if (!rst_n)               bc_q <= BC_RESET;
        else if (wr_hit[REG_BCNT]) bc_q <= wdata_i[BC_W-1:0];
    end

    // Read data selection
    always_comb begin
        case (addr_i)
            REG_OE:    rd_mux = oe_q;
            REG_SPR:   rd_mux = {strap_rb_i, sw_en_q, sw_code_q, 1'b1, amp_q};
            REG_SLEW:  rd_mux = slew_q;
            REG_REF:   rd_mux = {ref_slew_q, ref_wol_q, ref_en_q, 4'hF};
            REG_REVID: rd_mux = REV_VENDOR;
            REG_DEVID: rd_mux = DEVICE_ID;
            REG_BCNT:  rd_mux = {{BC_PAD{1'b0}}, bc_q};
            default:   rd_mux = '0;
        endcase
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign rdata_o    = rdata_q;
    assign oe_o       = oe_q;
    assign slew_o     = slew_q;
    assign sw_en_o    = sw_en_q;
    assign sw_code_o  = sw_code_q;
    assign amp_o      = amp_q;
    assign ref_slew_o = ref_slew_q;
    assign ref_wol_o  = ref_wol_q;
    assign ref_en_o   = ref_en_q;

    // R9: read data holds without a read strobe
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_q))
        else $error("read data moved without strobe");

    // R7: upper count bits always read zero
    a_r7_bcnt_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == REG_BCNT) |=> (rdata_q[DATA_W-1:BC_W] == '0))
        else $error("byte count upper bits nonzero");

    // R8: identity byte is constant
    a_r8_revid_const: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == REG_REVID) |=> (rdata_q == REV_VENDOR))
        else $error("revision byte changed");

    // R8: reserved register reads zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == REG_RSV) |=> (rdata_q == '0))
        else $error("reserved register nonzero");
endmodule

// File: rtl/clkcfg_regs.sv
`timescale 1ns/1ps
// Top of the configuration bank: strap latch, register file and spread select.
// Assumes strobes are low during reset and straps are valid at first startup.
module clkcfg_regs #(
    parameter int          BC_W       = 5,
    parameter logic [BC_W-1:0] BC_RESET = 5'd8,
    parameter logic [7:0]  REV_VENDOR = 8'h11,
    parameter logic [7:0]  DEVICE_ID  = 8'h08
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       startup_i,
    input  logic [1:0] ss_level_i,
    input  logic       addr_strap_i,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic [1:0] spread_mode_o,
    output logic [1:0] amp_code_o,
    output logic [7:0] out_en_o,
    output logic [7:0] out_slew_o,
    output logic [1:0] ref_slew_o,
    output logic       ref_wol_o,
    output logic       ref_en_o,
    output logic       addr_sel_o
);
    import clkcfg_pkg::*;

    logic [1:0] strap_lvl, strap_rb, sw_code;
    logic       sw_en, captured;

    clkcfg_strap_latch u_strap (
        .clk          (clk),
        .rst_n        (rst_n),
        .startup_i    (startup_i),
        .ss_level_i   (ss_level_i),
        .addr_strap_i (addr_strap_i),
        .ss_level_o   (strap_lvl),
        .addr_sel_o   (addr_sel_o),
        .captured_o   (captured)
    );

    clkcfg_reg_file #(
        .BC_W       (BC_W),
        .BC_RESET   (BC_RESET),
        .REV_VENDOR (REV_VENDOR),
        .DEVICE_ID  (DEVICE_ID)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .strap_rb_i (strap_rb),
        .rdata_o    (rdata_o),
        .oe_o       (out_en_o),
        .slew_o     (out_slew_o),
        .sw_en_o    (sw_en),
        .sw_code_o  (sw_code),
        .amp_o      (amp_code_o),
        .ref_slew_o (ref_slew_o),
        .ref_wol_o  (ref_wol_o),
        .ref_en_o   (ref_en_o)
    );

    clkcfg_spread_sel u_spread (
        .strap_level_i (strap_lvl),
        .sw_en_i       (sw_en),
        .sw_code_i     (sw_code),
        .mode_o        (spread_mode_o),
        .readback_o    (strap_rb)
    );

    // R5: reserved override code never yields spread
    a_r5_reserved_code_off: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && sw_code == 2'b10) |-> (spread_mode_o == SPR_OFF))
        else $error("reserved code produced spread");

    // R3: strap readback never shows the unused code 10
    a_r3_readback_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == REG_SPR) |=> (rdata_o[7:6] != 2'b10))
        else $error("illegal strap readback");

    // R4: without override and before capture, spread is off
    a_r4_off_before_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!captured && !sw_en) |-> (spread_mode_o == SPR_OFF))
        else $error("spread active before strap capture");
endmodule

// File: tb/clkcfg_regs_bench.sv
`timescale 1ns/1ps
module clkcfg_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       startup_i = 1'b0;
    logic [1:0] ss_level_i = 2'b00;
    logic       addr_strap_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [2:0] addr_i = 3'd0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic [1:0] spread_mode_o, amp_code_o, ref_slew_o;
    logic [7:0] out_en_o, out_slew_o;
    logic       ref_wol_o, ref_en_o, addr_sel_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    clkcfg_regs u_clkcfg_regs (
        .clk(clk), .rst_n(rst_n), .startup_i(startup_i), .ss_level_i(ss_level_i),
        .addr_strap_i(addr_strap_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .spread_mode_o(spread_mode_o), .amp_code_o(amp_code_o),
        .out_en_o(out_en_o), .out_slew_o(out_slew_o), .ref_slew_o(ref_slew_o),
        .ref_wol_o(ref_wol_o), .ref_en_o(ref_en_o), .addr_sel_o(addr_sel_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] lvl, input logic adr);
        @(negedge clk);
        rst_n = 1'b0; startup_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
        ss_level_i = lvl; addr_strap_i = adr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_startup();
        startup_i = 1'b1;
        @(negedge clk);
        startup_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    // R1 reset values, R8 constant bytes
    task automatic t_reset();
        logic [7:0] d;
        do_reset(2'b10, 1'b1);
        check("R1 out_en", out_en_o, 8'hFF);
        check("R1 out_slew", out_slew_o, 8'hFF);
        check("R1 amp", {6'd0, amp_code_o}, 8'h02);
        check("R1 spread", {6'd0, spread_mode_o}, 8'h00);
        check("R1 ref", {4'd0, ref_slew_o, ref_wol_o, ref_en_o}, 8'h05);
        check("R2 addr_sel before capture", {7'd0, addr_sel_o}, 8'h00);
        reg_read(3'd0, d); check("R1 reg0", d, 8'hFF);
        reg_read(3'd1, d); check("R1 reg1", d, 8'h06);
        reg_read(3'd2, d); check("R1 reg2", d, 8'hFF);
        reg_read(3'd3, d); check("R1 reg3", d, 8'h5F);
        reg_read(3'd7, d); check("R1 reg7", d, 8'h08);
        reg_read(3'd4, d); check("R8 reg4", d, 8'h00);
        reg_read(3'd5, d); check("R8 reg5", d, 8'h11);
        reg_read(3'd6, d); check("R8 reg6", d, 8'h08);
    endtask

    // R2 R3 R4 strap capture, readback and default spread
    task automatic t_strap(input logic [1:0] lvl, input logic adr,
                           input logic [1:0] exp_rb, input logic [1:0] exp_mode);
        logic [7:0] d;
        do_reset(lvl, adr);
        pulse_startup();
        check("R4 strap mode", {6'd0, spread_mode_o}, {6'd0, exp_mode});
        check("R2 addr_sel", {7'd0, addr_sel_o}, {7'd0, adr});
        reg_read(3'd1, d);
        check("R3 readback", {6'd0, d[7:6]}, {6'd0, exp_rb});
        ss_level_i = ~lvl; addr_strap_i = ~adr;
        pulse_startup();
        check("R2 mode frozen", {6'd0, spread_mode_o}, {6'd0, exp_mode});
        check("R2 addr frozen", {7'd0, addr_sel_o}, {7'd0, adr});
        reg_read(3'd1, d);
        check("R2 readback frozen", {6'd0, d[7:6]}, {6'd0, exp_rb});
    endtask

    // R5 software override of spread; R8 fixed bits of register 1
    task automatic t_override();
        logic [7:0] d;
        do_reset(2'b01, 1'b0);
        pulse_startup();
        reg_write(3'd1, 8'b000_11_0_10);
        check("R5 code ignored without enable", {6'd0, spread_mode_o}, 8'h01);
        reg_write(3'd1, 8'b001_00_0_10);
        check("R5 code 00", {6'd0, spread_mode_o}, 8'h00);
        reg_write(3'd1, 8'b001_01_0_10);
        check("R5 code 01", {6'd0, spread_mode_o}, 8'h01);
        reg_write(3'd1, 8'b001_10_0_10);
        check("R5 code 10 reserved", {6'd0, spread_mode_o}, 8'h00);
        reg_write(3'd1, 8'b001_11_0_10);
        check("R5 code 11", {6'd0, spread_mode_o}, 8'h02);
        reg_write(3'd1, 8'hFF);
        reg_read(3'd1, d);
        check("R8 reg1 fixed bits", d, 8'h7F);
        reg_write(3'd1, 8'h00);
        check("R4 strap after disable", {6'd0, spread_mode_o}, 8'h01);
    endtask

    // R6 output fields follow writes
    task automatic t_fields();
        logic [7:0] d;
        do_reset(2'b00, 1'b0);
        reg_write(3'd0, 8'hA5);
        check("R6 out_en", out_en_o, 8'hA5);
        reg_write(3'd2, 8'h3C);
        check("R6 out_slew", out_slew_o, 8'h3C);
        reg_write(3'd1, 8'h01);
        check("R6 amp", {6'd0, amp_code_o}, 8'h01);
        reg_write(3'd3, 8'h20);
        check("R6 ref", {4'd0, ref_slew_o, ref_wol_o, ref_en_o}, 8'h02);
        reg_write(3'd3, 8'hD0);
        check("R6 ref fast", {4'd0, ref_slew_o, ref_wol_o, ref_en_o}, 8'h0D);
        reg_read(3'd3, d);
        check("R8 reg3 low nibble", d, 8'hDF);
    endtask

    // R7 byte count field
    task automatic t_bcnt();
        logic [7:0] d;
        reg_write(3'd7, 8'hFF);
        reg_read(3'd7, d);
        check("R7 count max", d, 8'h1F);
        reg_write(3'd7, 8'hE3);
        reg_read(3'd7, d);
        check("R7 count value", d, 8'h03);
    endtask

    // R8 read-only registers ignore writes
    task automatic t_readonly();
        logic [7:0] d;
        do_reset(2'b00, 1'b0);
        reg_write(3'd4, 8'hFF);
        reg_write(3'd5, 8'h00);
        reg_write(3'd6, 8'hFF);
        reg_read(3'd4, d); check("R8 reg4 after write", d, 8'h00);
        reg_read(3'd5, d); check("R8 reg5 after write", d, 8'h11);
        reg_read(3'd6, d); check("R8 reg6 after write", d, 8'h08);
        check("R8 out_en untouched", out_en_o, 8'hFF);
        check("R8 out_slew untouched", out_slew_o, 8'hFF);
    endtask

    // R9 registered read latency and hold
    task automatic t_latency();
        logic [7:0] d;
        reg_write(3'd0, 8'h5A);
        reg_read(3'd0, d);
        check("R9 read data", d, 8'h5A);
        addr_i = 3'd5;
        @(negedge clk);
        check("R9 hold without strobe", rdata_o, 8'h5A);
        rd_en_i = 1'b1; addr_i = 3'd6;
        #1;
        check("R9 no same-cycle update", rdata_o, 8'h5A);
        @(negedge clk);
        rd_en_i = 1'b0;
        check("R9 next-cycle update", rdata_o, 8'h08);
    endtask

    initial begin
        t_reset();
        t_strap(2'b00, 1'b1, 2'b00, 2'b00);
        t_strap(2'b01, 1'b0, 2'b01, 2'b01);
        t_strap(2'b10, 1'b1, 2'b11, 2'b10);
        t_strap(2'b11, 1'b0, 2'b11, 2'b10);
        t_override();
        t_fields();
        t_bcnt();
        t_readonly();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule